// File: doc/BRIEF.md
# Power Domain Sequencer with Interconnect Idle Handshake

This block switches a set of separately gated power domains on and off under software control. Software writes a target word into a control register: a 1 in a domain's bit asks for that domain to be off, a 0 asks for it to be on. Each write is queued. A single sequencer takes the queued words one at a time and visits the domains from the lowest index upward. For every domain whose present state differs from the target, it runs the full transition.

Before power is cut, the interconnect port that serves the domain is asked to go idle. The sequencer waits for that port's acknowledge and then for its idle flag, and only then opens the power switch. Power-up runs the same steps in reverse. Domains built without a power switch only run the idle handshake. Domains built without an idle port only run the power step.

Switch transitions are timed by programmable counts. There is one count per switch group (core or graphics) and per direction. The power-status bit moves only when the count has run out. A simple model of the interconnect port sits inside the block. It acknowledges a programmable number of cycles after the request changes, and raises or drops its idle flag one cycle after the acknowledge does.

Top module: `pds_sequencer`

## Requirements
- R1: After reset every domain is on. STATUS (word 1), IDLE_REQ (word 2) and the busy bit (word 4, bit 0) read 0, and all switch pins are low. The four transition counts (words 8 to 11) read 24, and the acknowledge delay (word 5) reads 4.
- R2: When a domain with both an idle port and a switch goes off, its idle request rises first. Its switch pin rises only after both the acknowledge and the idle flag of that port are set.
- R3: When such a domain comes on, its switch pin falls first. Its idle request is released only once STATUS reports the domain on. The sequencer then waits for the acknowledge to clear and after that for the idle flag to clear.
- R4: STATUS bit i reads 1 when domain i is off. After a switch pin changes, the STATUS bit follows exactly N cycles later and stays unchanged until then. N is read from word 8 + 2*group + dir, where dir is 1 for power-up and group is 1 only for domain 2 (graphics).
- R5: Domain 3 has no switch. Its STATUS bit mirrors its idle flag, and going off or on only raises or releases its idle request.
- R6: Domain 1 has no idle port. Its transitions toggle only its switch pin and never its idle request.
- R7: A target bit that equals the domain's present state causes no switch or request activity.
- R8: Control words are served in arrival order, and the domains inside one word from lowest index to highest. Busy (word 4, bit 0) is 1 while a word is queued or being served.
- R9: In word 3, bit 16+i is the acknowledge of domain i's port and bit i is its idle flag. The acknowledge follows a change of the request after the number of cycles held in word 5, and the idle flag follows the acknowledge one cycle later.
- R10: Only one domain's switch pin changes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| pwr_sw_o | output | NUM_DOM | Power switch pins, 1 = power removed |
| idle_req_o | output | NUM_DOM | Idle requests to the interconnect ports |
| busy_o | output | 1 | Sequencer busy |

## Verification
The first pattern powers off the switch-only domain alone. Counting cycles from its switch pin to its STATUS bit checks that the programmed count is honoured and that status does not move early. The second pattern powers off the idle-only domain with a non-default delay. This measures the acknowledge and idle latencies apart from any switch timing. Two back-to-back words, all-off and then all-on, are checked event by event against an ordered expectation queue. This separates a design that reorders domains or steps from one that obeys the handshake order. A repeated word that matches the present state must produce no events. A graphics-domain power-up with its own up-count shows that the group and direction pick the right counter.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_DN_ACK,
        S_DN_IDLE,
        S_PWR,
        S_UP_ACK,
        S_UP_IDLE
    } seq_st_e;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_STATUS = 4'd1;
    localparam logic [3:0] A_REQ    = 4'd2;
    localparam logic [3:0] A_FLAGS  = 4'd3;
    localparam logic [3:0] A_SEQ    = 4'd4;
    localparam logic [3:0] A_ACKDLY = 4'd5;

    localparam int unsigned ACK_BIT_OFS = 16;

endpackage

// File: rtl/pds_cmd_fifo.sv
module pds_cmd_fifo #(
    parameter int unsigned W     = 4,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [PW:0]             cnt;
    } fifo_s;

    fifo_s q, d;
    logic  do_push, do_pop;

    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == (PW+1)'(DEPTH));
    assign data_o  = q.mem[q.rp];

    always_comb begin
        d       = q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            d.mem[q.wp] = data_i;
            d.wp = (q.wp == PW'(DEPTH-1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == PW'(DEPTH-1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + (PW+1)'(do_push) - (PW+1)'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8
    pop_when_filled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/pds_idle_port.sv
module pds_idle_port #(
    parameter int unsigned ACK_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [ACK_W-1:0] dly_i,
    output logic             ack_o,
    output logic             idle_o
);
    typedef struct packed {
        logic             ack;
        logic             idle;
        logic [ACK_W-1:0] cnt;
    } port_s;

    port_s q, d;

    assign ack_o  = q.ack;
    assign idle_o = q.idle;

    always_comb begin
        d      = q;
        d.idle = q.ack;
        if (req_i != q.ack) begin
            if ({1'b0, q.cnt} + 1'b1 >= {1'b0, dly_i}) begin
                d.ack = req_i;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ack) |-> $past(req_i));

    // R9
    ack_drop_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ack) |-> !$past(req_i));

endmodule

// File: rtl/pds_sequencer.sv
module pds_sequencer
    import pds_pkg::*;
#(
    parameter int unsigned         NUM_DOM    = 4,
    parameter logic [NUM_DOM-1:0]  HAS_PWR    = 'b0111,
    parameter logic [NUM_DOM-1:0]  HAS_REQ    = 'b1101,
    parameter logic [NUM_DOM-1:0]  GFX_MASK   = 'b0100,
    parameter int unsigned         CNT_W      = 8,
    parameter int unsigned         ACK_W      = 4,
    parameter int unsigned         FIFO_DEPTH = 4,
    parameter int unsigned         DEF_CNT    = 24,
    parameter int unsigned         DEF_ACK    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [3:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [3:0]         rd_addr,
    output logic [31:0]        rd_data,
    output logic [NUM_DOM-1:0] pwr_sw_o,
    output logic [NUM_DOM-1:0] idle_req_o,
    output logic               busy_o
);
    localparam int unsigned IW = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;

    typedef struct packed {
        seq_st_e               st;
        logic [NUM_DOM-1:0]    cmd;
        logic [IW-1:0]         idx;
        logic [CNT_W-1:0]      cnt;
        logic [NUM_DOM-1:0]    sw;
        logic [NUM_DOM-1:0]    stat;
        logic [NUM_DOM-1:0]    req;
        logic [NUM_DOM-1:0]    ctrl;
        logic [ACK_W-1:0]      ack_dly;
        logic [3:0][CNT_W-1:0] lim;
    } seq_s;

    seq_s q, d;

    logic [NUM_DOM-1:0] ack_w, idle_w, status_w;
    logic [NUM_DOM-1:0] fifo_dout;
    logic               fifo_empty, fifo_full, fifo_push, fifo_pop;
    logic [IW-1:0]      cur;
    logic               cur_off, adv;
    logic [CNT_W-1:0]   lim_dn, lim_up;
    logic               unused_bits;

    assign unused_bits = ^{wr_data, fifo_full};

    // interconnect port models, one per domain
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_port
        pds_idle_port #(.ACK_W(ACK_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_i  (q.req[g]),
            .dly_i  (q.ack_dly),
            .ack_o  (ack_w[g]),
            .idle_o (idle_w[g])
        );
        assign status_w[g] = HAS_PWR[g] ? q.stat[g] : idle_w[g];
    end

    assign fifo_push = wr_en && (wr_addr == A_CTRL);

    pds_cmd_fifo #(.W(NUM_DOM), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (fifo_push),
        .data_i  (wr_data[NUM_DOM-1:0]),
        .pop_i   (fifo_pop),
        .data_o  (fifo_dout),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    assign cur     = q.idx;
    assign cur_off = status_w[cur];
    assign lim_dn  = q.lim[{GFX_MASK[cur], 1'b0}];
    assign lim_up  = q.lim[{GFX_MASK[cur], 1'b1}];

    always_comb begin
        d        = q;
        fifo_pop = 1'b0;
        adv      = 1'b0;

        if (wr_en) begin
            if (wr_addr == A_CTRL)   d.ctrl    = wr_data[NUM_DOM-1:0];
            if (wr_addr == A_ACKDLY) d.ack_dly = wr_data[ACK_W-1:0];
            if (wr_addr[3])          d.lim[wr_addr[1:0]] = wr_data[CNT_W-1:0];
        end

        case (q.st)
            S_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    d.cmd    = fifo_dout;
                    d.idx    = '0;
                    d.st     = S_SCAN;
                end
            end
            S_SCAN: begin
                if ((q.cmd[cur] != cur_off) && (HAS_PWR[cur] || HAS_REQ[cur])) begin
                    if (q.cmd[cur]) begin
                        if (HAS_REQ[cur]) begin
                            d.req[cur] = 1'b1;
                            d.st       = S_DN_ACK;
                        end else begin
                            d.sw[cur] = 1'b1;
                            d.cnt     = lim_dn;
                            d.st      = S_PWR;
                        end
                    end else begin
                        if (HAS_PWR[cur]) begin
                            d.sw[cur] = 1'b0;
                            d.cnt     = lim_up;
                            d.st      = S_PWR;
                        end else begin
                            d.req[cur] = 1'b0;
                            d.st       = S_UP_ACK;
                        end
                    end
                end else begin
                    adv = 1'b1;
                end
            end
            S_DN_ACK: begin
                if (ack_w[cur]) d.st = S_DN_IDLE;
            end
            S_DN_IDLE: begin
                if (idle_w[cur]) begin
                    if (HAS_PWR[cur]) begin
                        d.sw[cur] = 1'b1;
                        d.cnt     = lim_dn;
                        d.st      = S_PWR;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            S_PWR: begin
                if (q.cnt <= CNT_W'(1)) begin
                    d.stat[cur] = q.sw[cur];
                    if (!q.sw[cur] && HAS_REQ[cur] && q.req[cur]) begin
                        d.req[cur] = 1'b0;
                        d.st       = S_UP_ACK;
                    end else begin
                        adv = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            S_UP_ACK: begin
                if (!ack_w[cur]) d.st = S_UP_IDLE;
            end
            S_UP_IDLE: begin
                if (!idle_w[cur]) adv = 1'b1;
            end
            default: d.st = S_IDLE;
        endcase

        if (adv) begin
            if (q.idx == IW'(NUM_DOM-1)) begin
                d.st = S_IDLE;
            end else begin
                d.idx = q.idx + 1'b1;
                d.st  = S_SCAN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ack_dly <= ACK_W'(DEF_ACK);
            q.lim     <= {4{CNT_W'(DEF_CNT)}};
        end else begin
            q <= d;
        end
    end

    assign pwr_sw_o   = q.sw;
    assign idle_req_o = q.req;
    assign busy_o     = (q.st != S_IDLE) || !fifo_empty;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:   rd_data[NUM_DOM-1:0] = q.ctrl;
            A_STATUS: rd_data[NUM_DOM-1:0] = status_w;
            A_REQ:    rd_data[NUM_DOM-1:0] = q.req;
            A_FLAGS: begin
                rd_data[NUM_DOM-1:0]            = idle_w;
                rd_data[ACK_BIT_OFS +: NUM_DOM] = ack_w;
            end
            A_SEQ:    rd_data[0] = busy_o;
            A_ACKDLY: rd_data[ACK_W-1:0] = q.ack_dly;
            default: begin
                if (rd_addr[3]) rd_data[CNT_W-1:0] = q.lim[rd_addr[1:0]];
            end
        endcase
    end

    for (genvar a = 0; a < NUM_DOM; a++) begin : g_chk
        // R2
        cut_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(q.sw[a]) && HAS_REQ[a]) |-> (idle_w[a] && ack_w[a] && q.req[a]));

        // R3
        release_after_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(q.req[a]) && HAS_PWR[a]) |-> (!q.sw[a] && !q.stat[a]));

        // R4
        status_at_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(q.stat[a]) |-> ($past(q.st) == S_PWR));

        // R6
        no_port_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !HAS_REQ[a] |-> !q.req[a]);
    end

    // R10
    single_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.sw ^ $past(q.sw)));

endmodule

// File: tb/pds_sequencer_test.sv
module pds_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam logic [N-1:0] HP = 4'b0111;
    localparam logic [N-1:0] HR = 4'b1101;
    localparam int EV_REQ = 0, EV_OFF = 1, EV_ON = 2, EV_CLR = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [N-1:0] pwr_sw_o, idle_req_o;
    logic        busy_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_q[$];
    logic [N-1:0] exp_off = '0;
    logic [N-1:0] prev_sw = '0, prev_req = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    pds_sequencer #(.NUM_DOM(N), .HAS_PWR(HP), .HAS_REQ(HR), .GFX_MASK(4'b0100))
    uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pwr_sw_o(pwr_sw_o),
        .idle_req_o(idle_req_o), .busy_o(busy_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // driver: push the expected event order, then issue the control word
    task automatic request(input logic [N-1:0] w);
        for (int i = 0; i < N; i++) begin
            if ((w[i] != exp_off[i]) && (HP[i] || HR[i])) begin
                if (w[i]) begin
                    if (HR[i]) exp_q.push_back(i*4 + EV_REQ);
                    if (HP[i]) exp_q.push_back(i*4 + EV_OFF);
                end else begin
                    if (HP[i]) exp_q.push_back(i*4 + EV_ON);
                    if (HR[i]) exp_q.push_back(i*4 + EV_CLR);
                end
                exp_off[i] = w[i];
            end
        end
        wr(4'd0, {28'd0, w});
    endtask

    task automatic wait_idle();
        int k = 0;
        while (busy_o && k < 5000) begin @(negedge clk); k++; end
    endtask

    // monitor: compare every observed switch/request change with the queue
    task automatic observe(input int code);
        if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected event", code, 32'hFFFF);
        end else begin
            int e = exp_q.pop_front();
            check(e == code, "R8 event order", code, e);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                if (pwr_sw_o[i] != prev_sw[i]) observe(i*4 + (pwr_sw_o[i] ? EV_OFF : EV_ON));
                if (idle_req_o[i] != prev_req[i]) observe(i*4 + (idle_req_o[i] ? EV_REQ : EV_CLR));
            end
        end
        prev_sw  = pwr_sw_o;
        prev_req = idle_req_o;
    end

    initial begin
        wait (cyc >= 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog R8 actual cycles=%0d expected below 100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(4'd1, v); check(v == 0, "R1 status", v, 0);
        rd(4'd2, v); check(v == 0, "R1 idle req", v, 0);
        rd(4'd4, v); check(v == 0, "R1 busy", v, 0);
        check(pwr_sw_o == 0, "R1 switches", pwr_sw_o, 0);
        for (int a = 8; a < 12; a++) begin
            rd(4'(a), v); check(v == 24, "R1 count default", v, 24);
        end
        rd(4'd5, v); check(v == 4, "R1 ack delay default", v, 4);

        // R4 R6: switch-only domain, core down-count of 10
        wr(4'd8, 32'd10);
        request(4'b0010);
        check(busy_o == 1'b1, "R8 busy after write", busy_o, 1);
        n = 0;
        while (!pwr_sw_o[1] && n < 100) begin @(negedge clk); n++; end
        rd(4'd1, v);
        n = 0;
        while (!rd_data[1] && n < 200) begin @(negedge clk); n++; end
        check(n == 10, "R4 status delay core down", n, 10);
        wait_idle();
        check(idle_req_o == 0, "R6 no request for domain 1", idle_req_o, 0);
        rd(4'd1, v); check(v == 4'b0010, "R4 status after off", v, 4'b0010);

        // R5 R9: idle-only domain with acknowledge delay 5
        wr(4'd5, 32'd5);
        request(4'b1010);
        n = 0;
        while (!idle_req_o[3] && n < 100) begin @(negedge clk); n++; end
        rd(4'd3, v);
        n = 0;
        while (!rd_data[19] && n < 100) begin @(negedge clk); n++; end
        check(n == 5, "R9 ack delay", n, 5);
        check(rd_data[3] == 1'b0, "R9 idle not before ack", rd_data[3], 0);
        @(negedge clk);
        check(rd_data[3] == 1'b1, "R9 idle one cycle after ack", rd_data[3], 1);
        wait_idle();
        check(pwr_sw_o == 4'b0010, "R5 no switch for domain 3", pwr_sw_o, 4'b0010);
        rd(4'd1, v); check(v == 4'b1010, "R5 status from idle flag", v, 4'b1010);

        // R2 R3 R8: two queued words, all off then all on
        wr(4'd5, 32'd2);
        request(4'b1111);
        request(4'b0000);
        wait_idle();
        rd(4'd1, v); check(v == 0, "R3 all on", v, 0);
        rd(4'd3, v); check(v == 0, "R3 acknowledge and idle clear", v, 0);
        check(exp_q.size() == 0, "R8 all events seen", exp_q.size(), 0);

        // R7: matching word does nothing
        request(4'b0000);
        repeat (8) @(negedge clk);
        check(busy_o == 1'b0, "R7 busy clears", busy_o, 0);
        check(pwr_sw_o == 0 && idle_req_o == 0, "R7 no activity", {pwr_sw_o, idle_req_o}, 0);

        // R4: graphics up-count of 7 on domain 2
        wr(4'd11, 32'd7);
        request(4'b0100);
        wait_idle();
        rd(4'd1, v); check(v == 4'b0100, "R2 graphics off", v, 4'b0100);
        request(4'b0000);
        n = 0;
        while (pwr_sw_o[2] && n < 100) begin @(negedge clk); n++; end
        rd(4'd1, v);
        n = 0;
        while (rd_data[2] && n < 200) begin @(negedge clk); n++; end
        check(n == 7, "R4 status delay graphics up", n, 7);
        wait_idle();
        check(exp_q.size() == 0, "R3 release completed", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule